// File: doc/BRIEF.md
# Serial Position Frame Assembler

This block packs an absolute position sample into one serial word and shifts it out one bit per shift strobe. The word always begins with the revolution count. An optional period-counter field follows it, and its width is chosen from the periods-per-revolution code. After that come up to two active-low status bits: an error bit and a battery-warning bit.

A frame begins with a one-cycle start strobe. On that strobe the block captures the counts, the configuration and the status word. The captured copy stays fixed until the frame ends, so the live inputs may change during shifting without any effect on the word. The block also drives an active-low error level that follows the error condition of the last captured status. It does this whether or not the error bit is part of the frame.

Top module: `pos_frame_tx`

## Requirements
- R1: `start_i` while idle captures a frame, and its first bit, the revolution count MSB, appears on `sdo_o` one clock later. Each `shift_i` pulse while busy moves to the next bit on the following clock, and the revolution count goes out MSB first.
- R2: With `per_out_en_i`=1 and `ppr_code_i` from 0x0001 to 0x00FF, an 8-bit field carrying `per_i[7:0]` MSB first follows the revolution data.
- R3: With `per_out_en_i`=1 and `ppr_code_i` at 0x0100 or above, a 16-bit field follows the revolution data. This field is `per_i` zero-extended, with its unused high bits sent as 0.
- R4: If `per_out_en_i`=0, or if `ppr_code_i`=0x0000, no period field is sent.
- R5: When `err_en_i`=1, an error bit follows the period field (or the revolution data if there is no period field). It is 0 when any bit of `status_i[7:0]` is set and 1 otherwise.
- R6: When `rst_err_en_i`=1, status bits 9, 10 and 11 (reset events) also count as errors. When it is 0 they are ignored.
- R7: When `wrn_en_i`=1, a warning bit is sent last. It is 0 when `status_i[8]` is set and 1 otherwise.
- R8: `nerr_o` is updated at each accepted start to the error condition of R5/R6, regardless of `err_en_i`.
- R9: Inputs that change after capture, and `start_i` asserted while busy, have no effect on the frame in progress or on `nerr_o`.
- R10: `done_o` is high for exactly one clock, in the cycle after the clock edge that shifts out the last bit. `sdo_o` is 0 whenever no frame is active.
- R11: After reset, `sdo_o`=0, `done_o`=0 and `nerr_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe |
| shift_i | input | 1 | Advance to the next bit |
| rev_i | input | REV_W | Revolution count |
| per_i | input | PER_W | Period count |
| ppr_code_i | input | 16 | Periods-per-revolution code |
| per_out_en_i | input | 1 | Period field enable |
| err_en_i | input | 1 | Error bit enable |
| wrn_en_i | input | 1 | Warning bit enable |
| rst_err_en_i | input | 1 | Count reset events as errors |
| status_i | input | 16 | Status word |
| sdo_o | output | 1 | Serial data |
| done_o | output | 1 | Frame finished pulse |
| nerr_o | output | 1 | Error level, active low |

## Verification
The bench targets the boundaries of the code: 0x0000 with the field enabled, 0x00FF, and 0x0100. A design with a misplaced threshold would send a field of the wrong length, and the bench sees this as a shifted error bit and a `done_o` in the wrong cycle. A period value above 255 in 16-bit mode shows whether the high bits are zero-extended or dropped. The reset-event bits are applied both with and without their enable, which catches an error bit or `nerr_o` that ignores the enable. The bench also changes every input and fires a stray start in the middle of a frame, which exposes any logic that reads the live inputs instead of the captured copy.

// File: rtl/pos_frame_pkg.sv
package pos_frame_pkg;
  // status[15:8] reset-event bits (power-down, preset, reboot): 9,10,11
  localparam logic [15:0] RST_EVT_MASK = 16'h0E00;
  localparam int unsigned WRN_BIT = 8;
  typedef enum logic [1:0] {PW_NONE, PW_8, PW_16} per_w_e;
endpackage

// File: rtl/frame_pack.sv
module frame_pack
  import pos_frame_pkg::*;
#(
  parameter int unsigned REV_W = 16,
  parameter int unsigned PER_W = 12,
  localparam int unsigned FRAME_W = REV_W + 18,
  localparam int unsigned LEN_W = $clog2(FRAME_W + 1)
) (
  input  logic [REV_W-1:0]   rev_i,
  input  logic [PER_W-1:0]   per_i,
  input  logic [15:0]        ppr_code_i,
  input  logic               per_out_en_i,
  input  logic               err_en_i,
  input  logic               wrn_en_i,
  input  logic               rst_err_en_i,
  input  logic [15:0]        status_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               err_n_o
);
  per_w_e      pw;
  logic [15:0] per16;
  logic        err_n, wrn_n;
  logic [1:0]  tail;
  int unsigned tail_n, pw_n;

  always_comb begin
    per16 = '0;
    per16[PER_W-1:0] = per_i;
  end

  always_comb begin
    if (!per_out_en_i || ppr_code_i == 16'h0000) pw = PW_NONE;
    else if (ppr_code_i[15:8] != 8'h00)          pw = PW_16;
    else                                         pw = PW_8;
  end

  assign err_n = ~((|status_i[7:0]) | (rst_err_en_i & (|(status_i & RST_EVT_MASK))));
  assign wrn_n = ~status_i[WRN_BIT];
  assign err_n_o = err_n;

  always_comb begin
    unique case ({err_en_i, wrn_en_i})
      2'b11:   begin tail = {err_n, wrn_n}; tail_n = 2; end
      2'b10:   begin tail = {err_n, 1'b0};  tail_n = 1; end
      2'b01:   begin tail = {wrn_n, 1'b0};  tail_n = 1; end
      default: begin tail = 2'b00;          tail_n = 0; end
    endcase
  end

  always_comb begin
    unique case (pw)
      PW_8:    begin frame_o = {rev_i, per16[7:0], tail, 8'h00}; pw_n = 8;  end
      PW_16:   begin frame_o = {rev_i, per16, tail};             pw_n = 16; end
      default: begin frame_o = {rev_i, tail, 16'h0000};          pw_n = 0;  end
    endcase
  end

  assign len_o = LEN_W'(REV_W + pw_n + tail_n);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FRAME_W = 34,
  localparam int unsigned LEN_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               sdo_o,
  output logic               done_o,
  output logic               busy_o,
  output logic               load_o,
  output logic [LEN_W-1:0]   cnt_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               busy_q, done_q;
  logic               last;

  assign load_o = start_i & ~busy_q;
  assign last   = busy_q & shift_i & (cnt_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load_o) begin
        sh_q   <= frame_i;
        cnt_q  <= len_i;
        busy_q <= 1'b1;
      end else if (busy_q && shift_i) begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign sdo_o  = busy_q & sh_q[FRAME_W-1];
  assign done_o = done_q;
  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pos_frame_tx.sv
module pos_frame_tx #(
  parameter int unsigned REV_W = 16,
  parameter int unsigned PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             shift_i,
  input  logic [REV_W-1:0] rev_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [15:0]      ppr_code_i,
  input  logic             per_out_en_i,
  input  logic             err_en_i,
  input  logic             wrn_en_i,
  input  logic             rst_err_en_i,
  input  logic [15:0]      status_i,
  output logic             sdo_o,
  output logic             done_o,
  output logic             nerr_o
);
  localparam int unsigned FRAME_W = REV_W + 18;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len, cnt;
  logic               err_n, busy, load;
  logic               nerr_q;

  frame_pack #(.REV_W(REV_W), .PER_W(PER_W)) i_pack (
    .rev_i, .per_i, .ppr_code_i, .per_out_en_i, .err_en_i, .wrn_en_i,
    .rst_err_en_i, .status_i,
    .frame_o(frame), .len_o(len), .err_n_o(err_n)
  );

  frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i, .rst_ni, .start_i, .shift_i,
    .frame_i(frame), .len_i(len),
    .sdo_o, .done_o, .busy_o(busy), .load_o(load), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   nerr_q <= 1'b1;
    else if (load) nerr_q <= err_n;
  end

  assign nerr_o = nerr_q;
endmodule

// File: rtl/pos_frame_chk.sv
module pos_frame_chk #(
  parameter int unsigned REV_W = 16,
  parameter int unsigned LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_i,
  input logic             sdo_o,
  input logic             done_o,
  input logic             nerr_o,
  input logic             busy,
  input logic             load,
  input logic [LEN_W-1:0] cnt
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy); // R10
  AST_IDLE_SDO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !load) |=> !sdo_o); // R10
  AST_HOLD_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !shift_i) |=> $stable(sdo_o)); // R9
  AST_NERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(nerr_o)); // R9
  AST_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt >= LEN_W'(REV_W))); // R1
endmodule

bind pos_frame_tx pos_frame_chk #(.REV_W(REV_W), .LEN_W(LEN_W)) i_chk (
  .clk_i, .rst_ni, .shift_i, .sdo_o, .done_o, .nerr_o,
  .busy, .load, .cnt
);

// File: tb/test_pos_frame_tx.sv
module test_pos_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int REV_W = 16;
  localparam int PER_W = 12;

  logic clk = 0, rst_n = 0;
  logic start = 0, shift = 0;
  logic [REV_W-1:0] rev = '0;
  logic [PER_W-1:0] per = '0;
  logic [15:0] code = '0, status = '0;
  logic pen = 0, een = 1, wen = 1, ren = 0;
  logic sdo, done, nerr;
  int checks = 0, errors = 0;
  logic exp_b [0:63];
  int exp_n;
  logic exp_nerr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pos_frame_tx #(.REV_W(REV_W), .PER_W(PER_W)) i_pos_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shift_i(shift),
    .rev_i(rev), .per_i(per), .ppr_code_i(code), .per_out_en_i(pen),
    .err_en_i(een), .wrn_en_i(wen), .rst_err_en_i(ren), .status_i(status),
    .sdo_o(sdo), .done_o(done), .nerr_o(nerr)
  );

  task automatic chk(string tag, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", tag, what, got, exp);
    end
  endtask

  task automatic build_exp;
    int pw;
    logic [15:0] p16;
    logic e;
    exp_n = 0;
    for (int i = REV_W - 1; i >= 0; i--) begin exp_b[exp_n] = rev[i]; exp_n++; end
    pw = (!pen || code == 0) ? 0 : (code >= 16'h0100 ? 16 : 8);
    p16 = 16'(per);
    for (int i = pw - 1; i >= 0; i--) begin exp_b[exp_n] = p16[i]; exp_n++; end
    e = ~((|status[7:0]) | (ren & (status[9] | status[10] | status[11])));
    if (een) begin exp_b[exp_n] = e; exp_n++; end
    if (wen) begin exp_b[exp_n] = ~status[8]; exp_n++; end
    exp_nerr = e;
  endtask

  // disturb: change all inputs after capture and fire a stray start mid-frame
  task automatic run_frame(string tag, bit disturb, int gap);
    build_exp();
    start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      rev = ~rev; per = ~per; code = ~code; status = ~status;
      pen = ~pen; een = ~een; wen = ~wen; ren = ~ren;
    end
    for (int i = 0; i < exp_n; i++) begin
      chk(tag, sdo, exp_b[i], $sformatf("bit %0d", i));
      chk(tag, done, 1'b0, $sformatf("early done at bit %0d", i));
      if (gap > 0 && i == 2) begin
        if (disturb) start = 1;
        repeat (gap) @(negedge clk);
        start = 0;
        chk(tag, sdo, exp_b[i], "sdo held during gap");
      end
      shift = 1;
      @(negedge clk);
      shift = 0;
    end
    chk("R10", done, 1'b1, "done after last bit");
    chk(tag, nerr, exp_nerr, "nerr_o");
    @(negedge clk);
    chk("R10", done, 1'b0, "done one cycle only");
    chk("R10", sdo, 1'b0, "idle sdo");
  endtask

  task automatic set_in(logic [REV_W-1:0] r, logic [PER_W-1:0] p, logic [15:0] c,
                        logic pe, logic ee, logic we, logic re, logic [15:0] st);
    rev = r; per = p; code = c; pen = pe; een = ee; wen = we; ren = re; status = st;
  endtask

  task automatic t_reset;
    chk("R11", sdo, 1'b0, "reset sdo");
    chk("R11", done, 1'b0, "reset done");
    chk("R11", nerr, 1'b1, "reset nerr");
  endtask

  task automatic t_rev_only;  // R1 R4
    set_in(16'hA5C3, 12'h123, 16'h0040, 0, 0, 0, 0, 16'h0000);
    run_frame("R1", 0, 0);
    set_in(16'h8001, 12'h0FF, 16'h0000, 1, 0, 0, 0, 16'h0000);
    run_frame("R4", 0, 3);
  endtask

  task automatic t_per8;  // R2
    set_in(16'h1234, 12'hFA5, 16'h0001, 1, 1, 1, 0, 16'h0000);
    run_frame("R2", 0, 0);
    set_in(16'hFFFF, 12'h05A, 16'h00FF, 1, 1, 0, 0, 16'h0000);
    run_frame("R2", 0, 0);
  endtask

  task automatic t_per16;  // R3
    set_in(16'h0F0F, 12'hB3C, 16'h0100, 1, 1, 1, 0, 16'h0000);
    run_frame("R3", 0, 0);
    set_in(16'h0001, 12'hFFF, 16'hFFFF, 1, 0, 1, 0, 16'h0000);
    run_frame("R3", 0, 0);
  endtask

  task automatic t_status;  // R5 R7 R8
    set_in(16'h3C3C, 12'h011, 16'h0010, 1, 1, 1, 0, 16'h0080);
    run_frame("R5", 0, 0);
    set_in(16'h3C3C, 12'h011, 16'h0010, 1, 1, 1, 0, 16'h0100);
    run_frame("R7", 0, 0);
    set_in(16'h7777, 12'h000, 16'h0000, 0, 0, 1, 0, 16'h0001);
    run_frame("R8", 0, 0);
  endtask

  task automatic t_rst_evt;  // R6
    set_in(16'h0102, 12'h003, 16'h0004, 1, 1, 1, 0, 16'h0E00);
    run_frame("R6", 0, 0);
    set_in(16'h0102, 12'h003, 16'h0004, 1, 1, 1, 1, 16'h0200);
    run_frame("R6", 0, 0);
    set_in(16'h0102, 12'h003, 16'h0004, 1, 1, 0, 1, 16'h0800);
    run_frame("R6", 0, 0);
  endtask

  task automatic t_capture;  // R9
    set_in(16'hC0DE, 12'h9AB, 16'h0200, 1, 1, 1, 0, 16'h0000);
    run_frame("R9", 1, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rev_only();
    t_per8();
    t_per16();
    t_status();
    t_rst_evt();
    t_capture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule